// File: doc/BRIEF.md
# CCK Code Word Encoder

This block turns a stream of data words into complementary-code-keyed chips for the two high data rates of a direct-sequence transmitter. At the lower CCK rate each accepted word contributes a nibble. At the higher rate it contributes a full byte. Two bits of every word advance a differential QPSK reference phase. The remaining bits pick the three other phases of an 8-chip complex code word. Every symbol comes out as eight complex chips. Each chip is one of the four unit points on the I/Q axes.

A chip strobe from the sample-rate logic steps through the chips. The upstream source offers words with a valid/ready handshake. Before the first data symbol, a phase-load strobe seeds the reference with the phase of the final header chip. The symbol parity then restarts at even, so the differential chain continues across the boundary between header and data. Scrambling, pulse shaping and header generation belong to neighbouring blocks.

Top module: `cck_encoder`

## Requirements
- R1: While reset (active low `rstN`) is asserted and afterwards until a word is accepted, `chipValid` is 0. Whenever `chipValid` is 0, `chipI` and `chipQ` are 0. Reset sets the reference phase to quadrant 0 and the symbol parity to even.
- R2: `inReady` is 1 only when the rate code is supported and `phaseLoad` is 0, and only when the encoder is idle or the last chip (index 7) is being stepped out in the same cycle. A word is accepted on a clock edge where `inValid` and `inReady` are both 1, and its chip 0 appears in the next cycle.
- R3: With `rateSel` = 2'b10 (5.5 Mbit/s), word bits 7:4 are ignored. φ2 = 2·d2+1, φ3 = 0 and φ4 = 2·d3, in quadrants.
- R4: With `rateSel` = 2'b11 (11 Mbit/s), φ2 = 2·d2+d3, φ3 = 2·d4+d5 and φ4 = 2·d6+d7, in quadrants. Here dk is word bit k.
- R5: φ1 = reference + Δ + (2 if the symbol is odd-numbered). Δ is taken from (d0,d1): (0,0)→0, (0,1)→1, (1,1)→2, (1,0)→3. φ1 becomes the new reference, and the symbol parity flips with each accepted word.
- R6: A `phaseLoad` pulse while idle loads `phaseLoadVal` (a quadrant) as the reference and makes the next symbol even-numbered. `inReady` is 0 in any cycle where `phaseLoad` is 1.
- R7: Chips go out in order 0..7, with quadrant sums c0=φ1+φ2+φ3+φ4, c1=φ1+φ3+φ4, c2=φ1+φ2+φ4, c3=φ1+φ4+2, c4=φ1+φ2+φ3, c5=φ1+φ3, c6=φ1+φ2+2, c7=φ1, all modulo 4. Quadrant q maps to (I,Q) = 0:(+1,0), 1:(0,+1), 2:(−1,0), 3:(0,−1). Each cycle with `chipEn` = 1 steps to the next chip, and the chip holds otherwise.
- R8: With `rateSel` = 2'b00 or 2'b01, no word is accepted.
- R9: A `phaseLoad` pulse while a symbol is being sent has no effect on the reference or the parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inWord | input | 8 | Data word, bit 0 consumed first |
| inValid | input | 1 | Data word offered |
| inReady | output | 1 | Word will be taken at this edge |
| rateSel | input | 2 | 10 = 5.5 Mbit/s, 11 = 11 Mbit/s, others unsupported |
| phaseLoad | input | 1 | Load reference phase from header end |
| phaseLoadVal | input | 2 | Quadrant of the final header chip |
| chipEn | input | 1 | Advance to the next chip |
| chipValid | output | 1 | A chip is being presented |
| chipI | output | 2 | In-phase chip, signed −1/0/+1 |
| chipQ | output | 2 | Quadrature chip, signed −1/0/+1 |

## Verification
On every cycle the assertions check the handshake rules: ready is blocked by a phase load, by an unsupported rate, and by a busy encoder that is not stepping. They also check that a chip holds when not strobed, that every valid chip lies on a unit axis point, and that outputs are zero when idle. Whether the right code word comes out can only be shown by the bench's scenarios, which compare each chip against a behavioural model. This covers the rate-dependent bit partitions, the odd-symbol rotation, the carrying of the reference across a phase load, and the ignoring of a load that arrives while busy.

// File: rtl/cck_pkg.sv
package cck_pkg;
  localparam int WORD_W = 8;
  localparam int CHIPS_PER_SYM = 8;
  localparam int CIDX_W = $clog2(CHIPS_PER_SYM);
  localparam logic [1:0] RATE_5M5 = 2'b10;
  localparam logic [1:0] RATE_11M = 2'b11;

  typedef logic [1:0] quad_t;

  typedef struct packed {
    logic accept;
    logic loadRef;
    logic oddSym;
    logic show;
  } ctrl_strobes_t;
endpackage

// File: rtl/cck_ctrl.sv
module cck_ctrl
  import cck_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        rateSel,
  input  logic              chipEn,
  input  logic              phaseLoad,
  output logic              inReady,
  output logic              chipValid,
  output logic [CIDX_W-1:0] chipIdx,
  output ctrl_strobes_t     stb
);
  localparam logic [CIDX_W-1:0] LAST_IDX = CIDX_W'(CHIPS_PER_SYM - 1);

  logic busy;
  logic oddFlag;
  logic [CIDX_W-1:0] idx;
  logic rateOk;
  logic lastStep;
  logic accept;

  assign rateOk   = (rateSel == RATE_5M5) || (rateSel == RATE_11M);
  assign lastStep = busy && chipEn && (idx == LAST_IDX);
  assign inReady  = rateOk && !phaseLoad && (!busy || lastStep);
  assign accept   = inValid && inReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy && chipEn) begin
      if (idx == LAST_IDX) busy <= 1'b0;
      else idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) oddFlag <= 1'b0;
    else if (phaseLoad && !busy) oddFlag <= 1'b0;
    else if (accept) oddFlag <= ~oddFlag;
  end

  assign chipValid   = busy;
  assign chipIdx     = idx;
  assign stb.accept  = accept;
  assign stb.loadRef = phaseLoad && !busy;
  assign stb.oddSym  = oddFlag;
  assign stb.show    = busy;
endmodule

// File: rtl/cck_dpath.sv
module cck_dpath
  import cck_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobes_t      stb,
  input  logic [WORD_W-1:0]  inWord,
  input  logic [1:0]         rateSel,
  input  quad_t              phaseLoadVal,
  input  logic [CIDX_W-1:0]  chipIdx,
  output logic signed [1:0]  chipI,
  output logic signed [1:0]  chipQ
);
  quad_t refPh, p1, p2, p3, p4;
  quad_t deltaPh, p1New, p2New, p3New, p4New;
  quad_t chipPh;

  // differential pair: bit 0 first, bit 1 second
  always_comb begin
    unique case ({inWord[0], inWord[1]})
      2'b00:   deltaPh = 2'd0;
      2'b01:   deltaPh = 2'd1;
      2'b11:   deltaPh = 2'd2;
      default: deltaPh = 2'd3;
    endcase
    p1New = refPh + deltaPh + (stb.oddSym ? 2'd2 : 2'd0);
    if (rateSel == RATE_11M) begin
      p2New = {inWord[2], inWord[3]};
      p3New = {inWord[4], inWord[5]};
      p4New = {inWord[6], inWord[7]};
    end else begin
      p2New = {inWord[2], 1'b1};
      p3New = 2'd0;
      p4New = {inWord[3], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPh <= 2'd0;
      p1 <= 2'd0; p2 <= 2'd0; p3 <= 2'd0; p4 <= 2'd0;
    end else if (stb.accept) begin
      refPh <= p1New;
      p1 <= p1New; p2 <= p2New; p3 <= p3New; p4 <= p4New;
    end else if (stb.loadRef) begin
      refPh <= phaseLoadVal;
    end
  end

  // chip k drops phi2/phi3/phi4 when index bit 0/1/2 is set; chips 3 and 6 are negated
  always_comb begin
    chipPh = p1
           + (chipIdx[0] ? 2'd0 : p2)
           + (chipIdx[1] ? 2'd0 : p3)
           + (chipIdx[2] ? 2'd0 : p4)
           + ((chipIdx == 3'd3 || chipIdx == 3'd6) ? 2'd2 : 2'd0);
    chipI = 2'sd0;
    chipQ = 2'sd0;
    if (stb.show) begin
      unique case (chipPh)
        2'd0:    chipI = 2'sd1;
        2'd1:    chipQ = 2'sd1;
        2'd2:    chipI = -2'sd1;
        default: chipQ = -2'sd1;
      endcase
    end
  end
endmodule

// File: rtl/cck_encoder.sv
module cck_encoder
  import cck_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        inWord,
  input  logic              inValid,
  output logic              inReady,
  input  logic [1:0]        rateSel,
  input  logic              phaseLoad,
  input  logic [1:0]        phaseLoadVal,
  input  logic              chipEn,
  output logic              chipValid,
  output logic signed [1:0] chipI,
  output logic signed [1:0] chipQ
);
  ctrl_strobes_t stb;
  logic [CIDX_W-1:0] chipIdx;

  cck_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .rateSel(rateSel),
    .chipEn(chipEn), .phaseLoad(phaseLoad), .inReady(inReady),
    .chipValid(chipValid), .chipIdx(chipIdx), .stb(stb)
  );

  cck_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .inWord(inWord), .rateSel(rateSel),
    .phaseLoadVal(phaseLoadVal), .chipIdx(chipIdx),
    .chipI(chipI), .chipQ(chipQ)
  );
endmodule

// File: rtl/cck_encoder_chk.sv
module cck_encoder_chk (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [1:0]        rateSel,
  input logic              phaseLoad,
  input logic              chipEn,
  input logic              chipValid,
  input logic signed [1:0] chipI,
  input logic signed [1:0] chipQ
);
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    !chipValid |-> (chipI == 2'sd0 && chipQ == 2'sd0));

  p_busy_blocks_r2: assert property (@(posedge clk) disable iff (!rstN)
    (chipValid && !chipEn) |-> !inReady);

  p_unit_point_r7: assert property (@(posedge clk) disable iff (!rstN)
    chipValid |-> ($countones({chipI != 2'sd0, chipQ != 2'sd0}) == 1));

  p_hold_chip_r7: assert property (@(posedge clk) disable iff (!rstN)
    (chipValid && !chipEn) |=> (chipValid && $stable(chipI) && $stable(chipQ)));

  p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> chipValid);

  p_load_blocks_r6: assert property (@(posedge clk) disable iff (!rstN)
    phaseLoad |-> !inReady);

  p_bad_rate_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rateSel[1] |-> !inReady);
endmodule

bind cck_encoder cck_encoder_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .rateSel(rateSel), .phaseLoad(phaseLoad), .chipEn(chipEn),
  .chipValid(chipValid), .chipI(chipI), .chipQ(chipQ)
);

// File: tb/sim_cck_encoder.sv
module sim_cck_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 50000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] inWord = 8'h00;
  logic inValid = 1'b0;
  logic inReady;
  logic [1:0] rateSel = 2'b11;
  logic phaseLoad = 1'b0;
  logic [1:0] phaseLoadVal = 2'b00;
  logic chipEn = 1'b0;
  logic chipValid;
  logic signed [1:0] chipI, chipQ;

  int nVec = 0, nBad = 0, cyc = 0, enMode = 0;
  bit done = 0;
  string curTag = "R1";

  // reference model state
  bit mBusy = 0, mOdd = 0;
  int mIdx = 0, mRef = 0;
  int mq[8];

  always #(CLK_PERIOD/2) clk = ~clk;

  cck_encoder u0 (
    .clk(clk), .rstN(rstN), .inWord(inWord), .inValid(inValid), .inReady(inReady),
    .rateSel(rateSel), .phaseLoad(phaseLoad), .phaseLoadVal(phaseLoadVal),
    .chipEn(chipEn), .chipValid(chipValid), .chipI(chipI), .chipQ(chipQ)
  );

  task automatic chk(string what, int act, int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s act=%0d exp=%0d at cycle %0d", curTag, what, act, exp, cyc);
    end
  endtask

  function automatic int qI(int q);
    return (q == 0) ? 1 : (q == 2) ? -1 : 0;
  endfunction
  function automatic int qQ(int q);
    return (q == 1) ? 1 : (q == 3) ? -1 : 0;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      if (!rstN) begin
        mBusy = 0; mOdd = 0; mIdx = 0; mRef = 0;
        chk("reset chipValid", int'(chipValid), 0);
        chk("reset chipI", int'(chipI), 0);
      end else begin
        bit eRdy, ob;
        ob = mBusy;
        eRdy = rateSel[1] && !phaseLoad && (!mBusy || (chipEn && mIdx == 7));
        chk("inReady", int'(inReady), int'(eRdy));
        chk("chipValid", int'(chipValid), int'(mBusy));
        chk("chipI", int'(chipI), mBusy ? qI(mq[mIdx]) : 0);
        chk("chipQ", int'(chipQ), mBusy ? qQ(mq[mIdx]) : 0);
        if (ob && chipEn) begin
          if (mIdx == 7) mBusy = 0; else mIdx++;
        end
        if (phaseLoad && !ob) begin
          mRef = int'(phaseLoadVal); mOdd = 0;
        end
        if (inValid && eRdy) begin
          int dq, a, b, c, e;
          case ({inWord[0], inWord[1]})
            2'b00: dq = 0;
            2'b01: dq = 1;
            2'b11: dq = 2;
            default: dq = 3;
          endcase
          a = (mRef + dq + (mOdd ? 2 : 0)) % 4;
          if (rateSel == 2'b11) begin
            b = 2*inWord[2] + inWord[3];
            c = 2*inWord[4] + inWord[5];
            e = 2*inWord[6] + inWord[7];
          end else begin
            b = 2*inWord[2] + 1;
            c = 0;
            e = 2*inWord[3];
          end
          mq[0] = (a+b+c+e) % 4; mq[1] = (a+c+e) % 4;
          mq[2] = (a+b+e) % 4;   mq[3] = (a+e+2) % 4;
          mq[4] = (a+b+c) % 4;   mq[5] = (a+c) % 4;
          mq[6] = (a+b+2) % 4;   mq[7] = a;
          mRef = a; mOdd = !mOdd; mBusy = 1; mIdx = 0;
        end
      end
    end
  end

  // chip strobe pattern generator
  initial forever begin
    @(posedge clk); #1;
    case (enMode)
      0: chipEn = 1'b1;
      1: chipEn = (cyc % 3) != 0;
      default: chipEn = 1'b0;
    endcase
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WATCHDOG && !done) begin
      done = 1;
      nBad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, WATCHDOG);
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  task automatic sendWord(input logic [7:0] w);
    bit hs;
    inValid = 1'b1;
    inWord = w;
    forever begin
      @(negedge clk); hs = inReady;
      @(posedge clk); #1;
      if (hs) break;
    end
    inValid = 1'b0;
  endtask

  task automatic loadPhase(input logic [1:0] v);
    phaseLoad = 1'b1;
    phaseLoadVal = v;
    @(posedge clk); #1;
    phaseLoad = 1'b0;
  endtask

  task automatic waitIdle();
    forever begin
      @(negedge clk);
      if (!chipValid) break;
    end
    @(posedge clk); #1;
  endtask

  initial begin
    curTag = "R1";
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    curTag = "R6";
    loadPhase(2'd1);
    curTag = "R4";
    enMode = 0;
    sendWord(8'h00); sendWord(8'hFF); sendWord(8'h5A); sendWord(8'hC3);
    sendWord(8'h81); sendWord(8'h3C);
    waitIdle();
    curTag = "R5";
    for (int i = 0; i < 4; i++) sendWord(8'h00);
    sendWord(8'h01); sendWord(8'h02); sendWord(8'h03);
    waitIdle();
    curTag = "R7";
    enMode = 1;
    sendWord(8'h96); sendWord(8'h27); sendWord(8'hE4);
    waitIdle();
    curTag = "R9";
    enMode = 2;
    sendWord(8'h11);
    loadPhase(2'd3);
    enMode = 1;
    waitIdle();
    sendWord(8'h44);
    waitIdle();
    curTag = "R3";
    rateSel = 2'b10;
    enMode = 0;
    for (int n = 0; n < 16; n++) sendWord(8'(n) | 8'hA0);
    waitIdle();
    curTag = "R6";
    loadPhase(2'd2);
    sendWord(8'h07); sendWord(8'hF9);
    waitIdle();
    curTag = "R8";
    rateSel = 2'b01;
    inValid = 1'b1; inWord = 8'h55;
    repeat (10) @(posedge clk);
    #1 rateSel = 2'b00;
    repeat (10) @(posedge clk);
    #1 inValid = 1'b0;
    rateSel = 2'b11;
    curTag = "R2";
    sendWord(8'h6B); sendWord(8'h9D);
    waitIdle();
    repeat (3) @(posedge clk);
    #1;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule